// File: doc/BRIEF.md
# Robbed-Bit Signaling Extractor

This block pulls robbed-bit signaling out of a framed T1 receive stream. Serial data arrives one bit per enabled clock, together with the frame index, channel index and bit index that an upstream framer has already aligned. In the signaling frames the block takes the last bit of each channel's 8-bit slot as that channel's signaling bit. D4 framing has a 12-frame multiframe and gives A and B. ESF framing has a 24-frame multiframe and gives A, B, C and D. Extraction runs all the time and cannot be disabled.

Captured bits go into a shadow store. All 24 channels move into a host-visible bank in one clock edge when the multiframe-end marker is sampled. The host sees a whole multiframe's signaling or none of it, and never a partly updated set. A one-cycle strobe marks each commit, so later logic can compare the new values against the values it kept. The bank holds zero from reset until the first commit.

Top module: `rbs_extract`

## Requirements
- R1: While reset is asserted and after it is released, until the first commit, every channel reads 0 and `sig_upd` is low.
- R2: A bit is captured only when `bit_en` is high, `bit_idx` is 7 (the slot's least significant bit) and `chan_idx` is below 24. Zero-based frame indexes 5, 11, 17 and 23 supply A, B, C and D, in that order.
- R3: The visible bank changes only at the clock edge that samples `mf_end` high. `sig_upd` is high for exactly the one cycle after that edge, and the bank already holds the new values in that cycle.
- R4: In ESF mode (`esf_mode`=1) a read returns `rd_sig` = {A,B,C,D}, with A at bit 3.
- R5: In D4 mode (`esf_mode`=0) a commit stores {A,B,0,0}. Only frame indexes 5 and 11 are signaling frames.
- R6: Bits with `bit_en` low, with a `bit_idx` other than 7, or in non-signaling frames have no effect on the committed values.
- R7: All 24 channels are committed in the same cycle. A bit captured in the same cycle as `mf_end` is included in that commit.
- R8: A read with `rd_chan` of 24 or above returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| esf_mode | input | 1 | 1 = 24-frame ESF, 0 = 12-frame D4 |
| bit_en | input | 1 | Receive bit valid |
| rx_bit | input | 1 | Serial receive data |
| frame_idx | input | 5 | Zero-based frame within the multiframe |
| chan_idx | input | 5 | Zero-based channel 0..23 |
| bit_idx | input | 3 | Bit within slot, 0 first, 7 last |
| mf_end | input | 1 | Multiframe-end marker; commits the shadow |
| rd_chan | input | 5 | Host read channel |
| rd_sig | output | 4 | Committed signaling of `rd_chan` |
| sig_upd | output | 1 | One-cycle commit strobe |

## Verification
The bench drives each signaling bit one cycle after a disabled cycle that carries the inverted value. It also fills every non-signaling bit 7 with random data. A design that ignored `bit_en`, or sampled the wrong frames, would commit that noise. The last D bit of an ESF multiframe (or the last B bit in D4) arrives in the same cycle as `mf_end`. A commit path that read only the registered shadow would report the previous multiframe's value for channel 23. Several cycles into the following multiframe the bench reads every channel again. A bank that let captures through early would already show new bits by then. D4 multiframes follow ESF ones, and C and D must then read zero instead of the stale ESF bits.

// File: rtl/rbs_pkg.sv
package rbs_pkg;
  localparam int NUM_CH      = 24;
  localparam int CH_W        = 5;
  localparam int SIG_W       = 4;
  localparam int SLOT_BITS   = 8;
  localparam int BIT_W       = 3;
  localparam int FRM_W       = 5;
  localparam int SIG_SPACING = 6;
  localparam int D4_SIGS     = 2;
  typedef enum logic {MODE_D4 = 1'b0, MODE_ESF = 1'b1} frm_mode_e;
endpackage

// File: rtl/rbs_slot_decode.sv
module rbs_slot_decode #(
  parameter int NUM_CH      = rbs_pkg::NUM_CH,
  parameter int CH_W        = rbs_pkg::CH_W,
  parameter int SIG_W       = rbs_pkg::SIG_W,
  parameter int SLOT_BITS   = rbs_pkg::SLOT_BITS,
  parameter int BIT_W       = rbs_pkg::BIT_W,
  parameter int FRM_W       = rbs_pkg::FRM_W,
  parameter int SIG_SPACING = rbs_pkg::SIG_SPACING,
  parameter int D4_SIGS     = rbs_pkg::D4_SIGS,
  localparam int SEL_W      = $clog2(SIG_W)
) (
  input  logic             bit_en,
  input  logic             esf_mode,
  input  logic [FRM_W-1:0] frame_idx,
  input  logic [CH_W-1:0]  chan_idx,
  input  logic [BIT_W-1:0] bit_idx,
  output logic             cap_en,
  output logic [SEL_W-1:0] cap_sel
);
  localparam logic [FRM_W:0] SPACE    = (FRM_W+1)'(SIG_SPACING);
  localparam logic [FRM_W:0] N_ESF    = (FRM_W+1)'(SIG_W);
  localparam logic [FRM_W:0] N_D4     = (FRM_W+1)'(D4_SIGS);
  localparam logic [BIT_W-1:0] LSB_POS = BIT_W'(SLOT_BITS - 1);
  localparam logic [CH_W-1:0]  CH_LIM  = CH_W'(NUM_CH);

  logic [FRM_W:0] frame_pos;
  logic [FRM_W:0] letter;
  logic [FRM_W:0] n_sigs;
  logic           sig_frame;

  always_comb begin
    frame_pos = {1'b0, frame_idx} + 1'b1;
    sig_frame = (frame_pos % SPACE) == '0;
    letter    = (frame_pos / SPACE) - 1'b1;
    n_sigs    = (esf_mode == rbs_pkg::MODE_ESF) ? N_ESF : N_D4;
    cap_en    = bit_en && (bit_idx == LSB_POS) && (chan_idx < CH_LIM) &&
                sig_frame && (letter < n_sigs);
    cap_sel   = letter[SEL_W-1:0];
  end
endmodule

// File: rtl/rbs_shadow.sv
module rbs_shadow #(
  parameter int NUM_CH = rbs_pkg::NUM_CH,
  parameter int CH_W   = rbs_pkg::CH_W,
  parameter int SIG_W  = rbs_pkg::SIG_W,
  localparam int SEL_W = $clog2(SIG_W)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cap_en,
  input  logic [SEL_W-1:0]              cap_sel,
  input  logic [CH_W-1:0]               cap_ch,
  input  logic                          cap_bit,
  output logic [NUM_CH-1:0][SIG_W-1:0]  shd_merged
);
  logic [NUM_CH-1:0][SIG_W-1:0] shd_q;
  logic [NUM_CH-1:0][SIG_W-1:0] shd_d;
  logic [SIG_W-1:0]             sel_oh;

  // next state: capture lands in the letter's position (A = MSB)
  always_comb begin
    sel_oh = '0;
    sel_oh[SEL_W'(SIG_W-1) - cap_sel] = 1'b1;
    shd_d  = shd_q;
    for (int ch = 0; ch < NUM_CH; ch++) begin
      if (cap_en && (cap_ch == CH_W'(ch))) begin
        shd_d[ch] = (shd_q[ch] & ~sel_oh) | (cap_bit ? sel_oh : '0);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      shd_q <= '0;
    else if (cap_en) shd_q <= shd_d;
  end

  // merged view lets a same-cycle capture join the commit
  assign shd_merged = shd_d;
endmodule

// File: rtl/rbs_bank.sv
module rbs_bank #(
  parameter int NUM_CH  = rbs_pkg::NUM_CH,
  parameter int CH_W    = rbs_pkg::CH_W,
  parameter int SIG_W   = rbs_pkg::SIG_W,
  parameter int D4_SIGS = rbs_pkg::D4_SIGS
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          commit,
  input  logic                          esf_mode,
  input  logic [NUM_CH-1:0][SIG_W-1:0]  shd_in,
  input  logic [CH_W-1:0]               rd_chan,
  output logic [SIG_W-1:0]              rd_sig,
  output logic                          sig_upd
);
  localparam logic [CH_W-1:0] CH_LIM = CH_W'(NUM_CH);

  logic [SIG_W-1:0] d4_mask;
  generate
    if (SIG_W > D4_SIGS) begin : g_mask
      assign d4_mask = {{D4_SIGS{1'b1}}, {(SIG_W-D4_SIGS){1'b0}}};
    end else begin : g_nomask
      assign d4_mask = '1;
    end
  endgenerate

  logic [NUM_CH-1:0][SIG_W-1:0] bank_q;
  logic [NUM_CH-1:0][SIG_W-1:0] bank_d;
  logic                         upd_q;

  always_comb begin
    for (int ch = 0; ch < NUM_CH; ch++) begin
      bank_d[ch] = (esf_mode == rbs_pkg::MODE_ESF) ? shd_in[ch]
                                                   : (shd_in[ch] & d4_mask);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bank_q <= '0;
    else if (commit) bank_q <= bank_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) upd_q <= 1'b0;
    else        upd_q <= commit;
  end

  always_comb begin
    rd_sig = '0;
    if (rd_chan < CH_LIM) rd_sig = bank_q[rd_chan];
  end

  assign sig_upd = upd_q;
endmodule

// File: rtl/rbs_extract.sv
module rbs_extract #(
  parameter int NUM_CH      = rbs_pkg::NUM_CH,
  parameter int CH_W        = rbs_pkg::CH_W,
  parameter int SIG_W       = rbs_pkg::SIG_W,
  parameter int SLOT_BITS   = rbs_pkg::SLOT_BITS,
  parameter int BIT_W       = rbs_pkg::BIT_W,
  parameter int FRM_W       = rbs_pkg::FRM_W,
  parameter int SIG_SPACING = rbs_pkg::SIG_SPACING,
  parameter int D4_SIGS     = rbs_pkg::D4_SIGS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             esf_mode,
  input  logic             bit_en,
  input  logic             rx_bit,
  input  logic [FRM_W-1:0] frame_idx,
  input  logic [CH_W-1:0]  chan_idx,
  input  logic [BIT_W-1:0] bit_idx,
  input  logic             mf_end,
  input  logic [CH_W-1:0]  rd_chan,
  output logic [SIG_W-1:0] rd_sig,
  output logic             sig_upd
);
  localparam int SEL_W = $clog2(SIG_W);

  // asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  logic rst_int_n;
  assign rst_int_n = rst_sync_q[1];

  logic             cap_en;
  logic [SEL_W-1:0] cap_sel;
  logic [NUM_CH-1:0][SIG_W-1:0] shd_merged;

  rbs_slot_decode #(
    .NUM_CH(NUM_CH), .CH_W(CH_W), .SIG_W(SIG_W), .SLOT_BITS(SLOT_BITS),
    .BIT_W(BIT_W), .FRM_W(FRM_W), .SIG_SPACING(SIG_SPACING), .D4_SIGS(D4_SIGS)
  ) u_dec (
    .bit_en(bit_en), .esf_mode(esf_mode), .frame_idx(frame_idx),
    .chan_idx(chan_idx), .bit_idx(bit_idx), .cap_en(cap_en), .cap_sel(cap_sel)
  );

  rbs_shadow #(.NUM_CH(NUM_CH), .CH_W(CH_W), .SIG_W(SIG_W)) u_shd (
    .clk(clk), .rst_n(rst_int_n), .cap_en(cap_en), .cap_sel(cap_sel),
    .cap_ch(chan_idx), .cap_bit(rx_bit), .shd_merged(shd_merged)
  );

  rbs_bank #(.NUM_CH(NUM_CH), .CH_W(CH_W), .SIG_W(SIG_W), .D4_SIGS(D4_SIGS)) u_bank (
    .clk(clk), .rst_n(rst_int_n), .commit(mf_end), .esf_mode(esf_mode),
    .shd_in(shd_merged), .rd_chan(rd_chan), .rd_sig(rd_sig), .sig_upd(sig_upd)
  );
endmodule

// File: rtl/rbs_extract_chk.sv
module rbs_extract_chk #(
  parameter int NUM_CH = rbs_pkg::NUM_CH,
  parameter int CH_W   = rbs_pkg::CH_W,
  parameter int SIG_W  = rbs_pkg::SIG_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic             esf_mode,
  input logic             mf_end,
  input logic [CH_W-1:0]  rd_chan,
  input logic [SIG_W-1:0] rd_sig,
  input logic             sig_upd
);
  localparam logic [CH_W-1:0] CH_LIM = CH_W'(NUM_CH);

  // R3: the bank is frozen between commits
  assert_bank_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(mf_end) && $stable(rd_chan)) |-> $stable(rd_sig));

  // R3: strobe follows the marker by one cycle
  assert_strobe_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mf_end |=> sig_upd);

  // R3: no strobe without a marker
  assert_strobe_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !mf_end |=> !sig_upd);

  // R5: a D4 commit leaves C and D clear
  assert_d4_cd_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mf_end && !esf_mode) |-> (rd_sig[SIG_W-3:0] == '0));

  // R8: reads beyond the last channel return zero
  assert_range_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_chan >= CH_LIM) |-> (rd_sig == '0));
endmodule

bind rbs_extract rbs_extract_chk #(.NUM_CH(NUM_CH), .CH_W(CH_W), .SIG_W(SIG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .esf_mode(esf_mode), .mf_end(mf_end),
  .rd_chan(rd_chan), .rd_sig(rd_sig), .sig_upd(sig_upd)
);

// File: tb/rbs_extract_bench.sv
module rbs_extract_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       esf_mode;
  logic       bit_en;
  logic       rx_bit;
  logic [4:0] frame_idx;
  logic [4:0] chan_idx;
  logic [2:0] bit_idx;
  logic       mf_end;
  logic [4:0] rd_chan;
  logic [3:0] rd_sig;
  logic       sig_upd;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  logic [3:0] exp_q[$];
  logic [3:0] pat [24];
  logic [3:0] last_seen [24];

  always #2.5 clk = ~clk;

  rbs_extract u_rbs_extract (
    .clk(clk), .rst_n(rst_n), .esf_mode(esf_mode), .bit_en(bit_en),
    .rx_bit(rx_bit), .frame_idx(frame_idx), .chan_idx(chan_idx),
    .bit_idx(bit_idx), .mf_end(mf_end), .rd_chan(rd_chan),
    .rd_sig(rd_sig), .sig_upd(sig_upd)
  );

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // driver: pushes expected values, then plays one multiframe
  task automatic drive_mf(input bit esf);
    int nf;
    nf = esf ? 24 : 12;
    for (int ch = 0; ch < 24; ch++)
      exp_q.push_back(esf ? pat[ch] : {pat[ch][3:2], 2'b00});
    for (int f = 0; f < nf; f++)
      for (int c = 0; c < 24; c++)
        for (int b = 0; b < 8; b++) begin
          bit   sig;
          logic v;
          sig = (b == 7) && (((f + 1) % 6) == 0);
          v   = sig ? pat[c][3 - ((f + 1) / 6 - 1)] : 1'b0;
          if (sig) begin
            // R6: a disabled cycle carrying the wrong value
            @(negedge clk);
            esf_mode = esf; bit_en = 1'b0; rx_bit = ~v; mf_end = 1'b0;
            frame_idx = 5'(f); chan_idx = 5'(c); bit_idx = 3'(b);
          end
          @(negedge clk);
          esf_mode  = esf;
          bit_en    = 1'b1;
          rx_bit    = sig ? v : 1'($urandom);
          frame_idx = 5'(f); chan_idx = 5'(c); bit_idx = 3'(b);
          // R7: marker coincides with the final signaling bit
          mf_end    = (f == nf - 1) && (c == 23) && (b == 7);
        end
    @(negedge clk);
    bit_en = 1'b0; mf_end = 1'b0;
  endtask

  // monitor: owns rd_chan, compares bank against the scoreboard
  initial begin
    rd_chan = '0;
    @(posedge rst_n);
    repeat (3) @(negedge clk);
    check("R1 strobe after reset", {3'b0, sig_upd}, 4'h0);
    for (int ch = 0; ch < 24; ch++) begin
      rd_chan = 5'(ch); #1;
      check("R1 reset bank", rd_sig, 4'h0);
      @(negedge clk);
    end
    forever begin
      @(negedge clk);
      if (sig_upd) begin
        @(negedge clk);
        check("R3 strobe one cycle", {3'b0, sig_upd}, 4'h0);
        for (int ch = 0; ch < 24; ch++) begin
          logic [3:0] e;
          rd_chan = 5'(ch); #1;
          e = exp_q.pop_front();
          last_seen[ch] = e;
          check($sformatf("R2 R4 R5 R7 chan %0d", ch), rd_sig, e);
          @(negedge clk);
        end
        for (int ch = 24; ch < 32; ch++) begin
          rd_chan = 5'(ch); #1;
          check("R8 out of range", rd_sig, 4'h0);
          @(negedge clk);
        end
        repeat (1500) @(negedge clk);
        for (int ch = 0; ch < 24; ch++) begin
          rd_chan = 5'(ch); #1;
          check($sformatf("R3 R6 hold chan %0d", ch), rd_sig, last_seen[ch]);
          @(negedge clk);
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(negedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; esf_mode = 1'b1; bit_en = 1'b0; rx_bit = 1'b0;
    frame_idx = '0; chan_idx = '0; bit_idx = '0; mf_end = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (40) @(negedge clk);
    for (int ch = 0; ch < 24; ch++) pat[ch] = 4'($urandom);
    drive_mf(1'b1);
    for (int ch = 0; ch < 24; ch++) pat[ch] = ~pat[ch];
    drive_mf(1'b1);
    for (int ch = 0; ch < 24; ch++) pat[ch] = 4'($urandom) | 4'b0011;
    drive_mf(1'b0);
    for (int ch = 0; ch < 24; ch++) pat[ch] = 4'(ch);
    drive_mf(1'b0);
    for (int ch = 0; ch < 24; ch++) pat[ch] = 4'hF;
    drive_mf(1'b1);
    for (int ch = 0; ch < 24; ch++) pat[ch] = (ch % 2 == 0) ? 4'hA : 4'h5;
    drive_mf(1'b1);
    repeat (2500) @(negedge clk);
    check("R7 scoreboard drained", 4'(exp_q.size()), 4'h0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule